// File: doc/BRIEF.md
# Global-History Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps only direction information. There is no target field, so target addresses have to be computed somewhere else during decode. A global history register records the most recent predicted directions. That history is XORed with low fetch-address bits to select one 2-bit saturating counter in a pattern table. The upper bit of the selected counter is the prediction. With `IDX_W` set to 13, the table holds 8192 counters. The default is smaller so that the block elaborates quickly.

The front end calls the lookup port once for each conditional branch it fetches. The block returns the prediction and also presents the history value that was used, as a checkpoint. The front end carries that checkpoint along with the branch. At retirement the update port receives:

- the branch address bits,
- the checkpoint,
- the actual direction,
- a misprediction flag.

The update moves the counter that the lookup used one step towards the actual outcome. When the flag is set, the update also rebuilds the history from the checkpoint plus the actual outcome. This discards the history built up on the wrong path.

Top module: `gshare_dir_pred`

## Requirements
- R1: After reset every counter holds 01 (weakly not-taken), so every lookup predicts not-taken, and the history register is all zeros.
- R2: The lookup index is the history register XOR `lk_pc[IDX_W-1:0]`.
- R3: `lk_taken` is the upper bit of the selected counter: values 10 and 11 predict taken, and 00 and 01 predict not-taken.
- R4: An update with `up_taken`=1 increments the selected counter, and the counter stays at 11 once it reaches 11.
- R5: An update with `up_taken`=0 decrements the selected counter, and the counter stays at 00 once it reaches 00.
- R6: On a lookup with `lk_valid`=1, the history shifts left by one. The predicted direction enters bit 0 and the old top bit is dropped. `lk_ckpt` shows the history from before the shift.
- R7: While `lk_valid`=0 and no mispredicting update is presented, the history does not change.
- R8: An update with `up_mispred`=1 loads the history with `{up_ckpt[HIST_W-2:0], up_taken}`. This takes priority over any lookup in the same cycle.
- R9: An update with `up_mispred`=0 leaves the history untouched.
- R10: When a lookup and an update select the same counter in the same cycle, the lookup sees the counter value after the update.
- R11: The update index is `up_ckpt` XOR `up_pc[IDX_W-1:0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | A conditional branch is being looked up this cycle |
| lk_pc | input | IDX_W | Low bits of the fetch address |
| lk_taken | output | 1 | Predicted direction (1 = taken) |
| lk_ckpt | output | IDX_W | History used by this lookup, to be kept with the branch |
| up_valid | input | 1 | A retiring conditional branch updates the table |
| up_pc | input | IDX_W | Low bits of the retiring branch address |
| up_taken | input | 1 | Actual direction of the retiring branch |
| up_mispred | input | 1 | The retiring branch was mispredicted |
| up_ckpt | input | IDX_W | History checkpoint taken at that branch's lookup |

## Verification
The bench builds the block with `IDX_W`=4. This gives a 16-entry table and a 4-bit history, so every counter can be walked to both saturation limits. Every history value is reached by shifting and by repair. The bench forces lookup/update index collisions on purpose. It also runs several thousand cycles of mixed random traffic against an arithmetic model of the counters and the history.

// File: rtl/gshare_dir_pred.sv
module gshare_dir_pred #(
  parameter int IDX_W = 10,
  localparam int HIST_W = IDX_W,
  localparam int ENTRIES = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [IDX_W-1:0]  lk_pc,
  output logic              lk_taken,
  output logic [HIST_W-1:0] lk_ckpt,
  input  logic              up_valid,
  input  logic [IDX_W-1:0]  up_pc,
  input  logic              up_taken,
  input  logic              up_mispred,
  input  logic [HIST_W-1:0] up_ckpt
);

  logic [1:0]        pht [ENTRIES];
  logic [HIST_W-1:0] ghr;
  logic [IDX_W-1:0]  lk_idx, up_idx;
  logic [1:0]        up_cur, up_next, lk_cnt;
  logic              repair;

  assign lk_idx = ghr ^ lk_pc;
  assign up_idx = up_ckpt ^ up_pc;
  assign up_cur = pht[up_idx];
  assign repair = up_valid && up_mispred;

  always_comb begin
    if (up_taken) up_next = (up_cur == 2'b11) ? 2'b11 : up_cur + 2'b01;
    else          up_next = (up_cur == 2'b00) ? 2'b00 : up_cur - 2'b01;
  end

  assign lk_cnt   = (up_valid && up_idx == lk_idx) ? up_next : pht[lk_idx];
  assign lk_taken = lk_cnt[1];
  assign lk_ckpt  = ghr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) pht[i] <= 2'b01;
      ghr <= '0;
    end else begin
      if (up_valid) pht[up_idx] <= up_next;
      if (repair)        ghr <= {up_ckpt[HIST_W-2:0], up_taken};
      else if (lk_valid) ghr <= {ghr[HIST_W-2:0], lk_taken};
    end
  end

  a_r6_shift_in_prediction: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && !repair |=> lk_ckpt == {$past(lk_ckpt[HIST_W-2:0]), $past(lk_taken)});

  a_r7_history_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid && !repair |=> $stable(lk_ckpt));

  a_r8_history_repair: assert property (@(posedge clk) disable iff (!rst_n)
    repair |=> lk_ckpt == {$past(up_ckpt[HIST_W-2:0]), $past(up_taken)});

  a_r4_taken_leaves_zero: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid && up_taken |=> pht[$past(up_idx)] != 2'b00);

  a_r5_not_taken_leaves_three: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid && !up_taken |=> pht[$past(up_idx)] != 2'b11);

endmodule

// File: tb/test_gshare_dir_pred.sv
`timescale 1ns/1ps
module test_gshare_dir_pred;
  localparam int IW = 4;
  localparam int N  = 1 << IW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lk_valid = 1'b0;
  logic [IW-1:0] lk_pc = '0;
  logic          lk_taken;
  logic [IW-1:0] lk_ckpt;
  logic          up_valid = 1'b0;
  logic [IW-1:0] up_pc = '0;
  logic          up_taken = 1'b0;
  logic          up_mispred = 1'b0;
  logic [IW-1:0] up_ckpt = '0;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  logic [1:0]    m_cnt [N];
  logic [IW-1:0] m_ghr;

  always #2.5 clk = ~clk;

  gshare_dir_pred #(.IDX_W(IW)) i_gshare_dir_pred (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_taken(lk_taken), .lk_ckpt(lk_ckpt),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken),
    .up_mispred(up_mispred), .up_ckpt(up_ckpt)
  );

  task automatic chk(input string tag, input string what, input int got, input int exp);
    nchk++;
    if (got != exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, got, exp);
    end
  endtask

  function automatic logic [1:0] sat(input logic [1:0] c, input logic t);
    if (t) return (c == 2'd3) ? 2'd3 : c + 2'd1;
    return (c == 2'd0) ? 2'd0 : c - 2'd1;
  endfunction

  task automatic cyc(input string tag, input logic lv, input logic [IW-1:0] lpc,
                     input logic uv, input logic [IW-1:0] upc, input logic ut,
                     input logic um, input logic [IW-1:0] uck);
    logic [IW-1:0] li, ui;
    logic [1:0] nc;
    logic pe;
    @(negedge clk);
    lk_valid = lv; lk_pc = lpc;
    up_valid = uv; up_pc = upc; up_taken = ut; up_mispred = um; up_ckpt = uck;
    #1;
    li = m_ghr ^ lpc;
    ui = uck ^ upc;
    nc = sat(m_cnt[ui], ut);
    pe = (uv && ui == li) ? nc[1] : m_cnt[li][1];
    chk(tag, "lk_taken", int'(lk_taken), int'(pe));
    chk(tag, "lk_ckpt", int'(lk_ckpt), int'(m_ghr));
    @(posedge clk);
    if (uv) m_cnt[ui] = nc;
    if (uv && um) m_ghr = {uck[IW-2:0], ut};
    else if (lv) m_ghr = {m_ghr[IW-2:0], pe};
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      nfail++;
      nchk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) m_cnt[i] = 2'b01;
    m_ghr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 R3: reset state, every entry weakly not-taken
    for (int p = 0; p < N; p++) cyc("R1", 1'b0, IW'(p), 1'b0, '0, 1'b0, 1'b0, '0);

    // R4 R11: walk every counter up to saturation through varied ckpt/pc pairs
    for (int i = 0; i < N; i++)
      for (int k = 0; k < 5; k++)
        cyc("R4", 1'b0, IW'(i) ^ m_ghr, 1'b1, IW'(i) ^ IW'(k), 1'b1, 1'b0, IW'(k));
    for (int p = 0; p < N; p++) cyc("R3", 1'b0, IW'(p), 1'b0, '0, 1'b0, 1'b0, '0);

    // R5: walk every counter down to zero
    for (int i = 0; i < N; i++)
      for (int k = 0; k < 5; k++)
        cyc("R5", 1'b0, IW'(i), 1'b1, IW'(i) ^ IW'(k + 3), 1'b0, 1'b0, IW'(k + 3));
    for (int p = 0; p < N; p++) cyc("R5", 1'b0, IW'(p), 1'b0, '0, 1'b0, 1'b0, '0);

    // R2 R6: lookups shift predictions into history; train a few entries taken first
    for (int i = 0; i < N; i += 3)
      repeat (3) cyc("R4", 1'b0, '0, 1'b1, IW'(i), 1'b1, 1'b0, '0);
    for (int i = 0; i < 40; i++) cyc("R6", 1'b1, IW'(i * 7), 1'b0, '0, 1'b0, 1'b0, '0);

    // R7 R9: idle lookups and non-mispredicting updates keep history
    for (int i = 0; i < 20; i++)
      cyc("R9", 1'b0, IW'(i), 1'b1, IW'(i * 5), i[0], 1'b0, IW'(i * 3));
    for (int i = 0; i < 10; i++) cyc("R7", 1'b0, IW'(i), 1'b0, '0, 1'b0, 1'b0, '0);

    // R8: repair every checkpoint value, with a competing lookup
    for (int c = 0; c < N; c++)
      for (int t = 0; t < 2; t++) begin
        cyc("R8", 1'b1, IW'(c + 1), 1'b1, IW'(c * 3), t[0], 1'b1, IW'(c));
        cyc("R8", 1'b0, IW'(c), 1'b0, '0, 1'b0, 1'b0, '0);
      end

    // R10: same-index collision for every index and both directions
    for (int i = 0; i < N; i++)
      for (int k = 0; k < 4; k++)
        cyc("R10", 1'b0, IW'(i) ^ m_ghr, 1'b1, IW'(i) ^ IW'(k), k < 2, 1'b0, IW'(k));

    // R2 R11: mixed random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [IW-1:0] a, b, ck;
      a = IW'($urandom); b = IW'($urandom); ck = IW'($urandom);
      if (i % 5 == 0) b = a ^ m_ghr ^ ck;
      cyc((i % 2) ? "R2" : "R11", 1'($urandom), a, 1'($urandom), b,
          1'($urandom), ($urandom % 6) == 0, ck);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule